// File: doc/BRIEF.md
# Biquad Coefficient RAM Loader

This block sits between a byte-wide host register bus and the coefficient store of an audio filter engine. The host writes a target coefficient index and fills a fifteen-byte staging window. It then sets one bit of a command register. The block then moves one coefficient or a full five-coefficient biquad set between the staging window and the coefficient RAM, in either direction. Each coefficient is a signed 24-bit fixed-point fraction spanning about -1 to +1, and a negative value inverts phase. Within the staging window, coefficient k occupies bytes 3k to 3k+2 with its most significant byte at the lowest offset. The five coefficients of a set, in staging order, are b1, b2, a1, a2 and b0.

A five-coefficient write is captured into a shadow copy when it is accepted. It reaches the RAM only on a sample-frame strobe, and all five entries change in the same clock. A running filter therefore never reads a half-updated biquad. The filter reads the RAM through its own combinational index/data port. Biquad sets normally sit at indices that are multiples of 5 from 0 to 45. Indices 50 to 61 hold single scale and mix values.

Top module: `coef_loader`

## Requirements
- R1: After reset, every RAM entry, every staging byte, the index register, the command bits, busy and error all read as zero.
- R2: Bus offsets 0x00 to 0x0E read and write the staging bytes. Offset 0x10 holds the 6-bit coefficient index, and its upper two bits read as zero. Offset 0x11 is the command register. Offset 0x12 is status, with bit 0 for busy and bit 1 for error. Any other offset reads zero.
- R3: Command bit 0 writes staging bytes 0..2 as one coefficient, MSB first, to the RAM entry at the index. The filter port shows the new value from the second rising edge after the command write.
- R4: Command bit 1 captures all 15 staging bytes when it is accepted. The five RAM entries from the index upward stay unchanged until the first rising edge after acceptance at which the frame strobe is high. At that edge all five change together. Staging writes made while the commit is pending do not alter what is committed, and a strobe with no pending commit has no effect.
- R5: Command bit 2 loads the RAM entry at the index into staging bytes 0..2 on the edge after acceptance and leaves the other staging bytes unchanged.
- R6: Command bit 3 loads the five RAM entries from the index upward into all 15 staging bytes on the edge after acceptance.
- R7: Command bits 0, 2 and 3 clear themselves on the edge that performs the transfer. Bit 1 clears on the committing edge. Command bits 7..4 always read back the value last written to them.
- R8: Status bit 0 is high exactly while a command bit is set.
- R9: A command with any of bits 3..0 set that is written while busy is ignored, and it sets the sticky error bit.
- R10: A command with more than one of bits 3..0 set, a single-entry command whose index exceeds 61, or a five-entry command whose index exceeds 57 is ignored and sets the error bit. Any write to status clears the error bit.
- R11: Writing zero to command bits 3..0 starts nothing, cancels nothing and does not set the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register offset for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| frame_sync | input | 1 | Sample-frame boundary strobe |
| flt_idx | input | 6 | Filter read index |
| flt_coef | output | 24 | Coefficient at flt_idx, zero when the index exceeds 61 |

## Verification
Assertions checked on every cycle cover these properties: at most one command is active at a time, and short transfers finish in exactly one cycle. A pending commit holds until a strobe arrives. Every active command has an in-range index. A command written while busy always raises the error bit. What assertions cannot show needs the bench's scenarios: the contents of the RAM and the staging window, the byte order within a coefficient, that all five entries appear in the same cycle, and that staging edits after acceptance are not committed. The bench's reference model tracks these values on every clock.

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int NCOEF = 62,
  parameter int SET   = 5,
  parameter int CW    = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [4:0]                bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  input  logic                      frame_sync,
  input  logic [$clog2(NCOEF)-1:0]  flt_idx,
  output logic [CW-1:0]             flt_coef
);
  localparam int NB  = CW / 8;
  localparam int SB  = SET * NB;
  localparam int AW  = $clog2(NCOEF);
  localparam int SBW = $clog2(SB);
  localparam logic [4:0] A_IDX  = 5'h10;
  localparam logic [4:0] A_CMD  = 5'h11;
  localparam logic [4:0] A_STAT = 5'h12;

  logic [7:0]    stage  [SB];
  logic [CW-1:0] mem    [NCOEF];
  logic [CW-1:0] shadow [SET];
  logic [AW-1:0] idx_q, base_q;
  logic [3:0]    op_q, rsv_q;
  logic          err_q;

  logic       busy, wr_cmd, wide, bad, accept, reject;
  logic [3:0] req;
  logic [AW:0] lim;

  assign busy   = |op_q;
  assign wr_cmd = bus_wr && bus_addr == A_CMD;
  assign req    = bus_wdata[3:0];
  assign wide   = req[1] | req[3];
  assign lim    = {1'b0, idx_q} + (wide ? (AW+1)'(SET-1) : '0);
  assign bad    = busy || ((req & (req - 4'd1)) != 4'd0) || lim > (AW+1)'(NCOEF-1);
  assign accept = wr_cmd && req != 4'd0 && !bad;
  assign reject = wr_cmd && req != 4'd0 && bad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q   <= '0;
      rsv_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_cmd) rsv_q <= bus_wdata[7:4];
      if (bus_wr && bus_addr == A_IDX) idx_q <= bus_wdata[AW-1:0];
      if (bus_wr && bus_addr == A_STAT) err_q <= 1'b0;
      else if (reject) err_q <= 1'b1;
      if (accept) begin
        op_q   <= req;
        base_q <= idx_q;
      end else if (op_q[0] || op_q[2] || op_q[3] || (op_q[1] && frame_sync))
        op_q <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < SET; k++) shadow[k] <= '0;
    end else if (accept && req[1]) begin
      for (int k = 0; k < SET; k++)
        for (int j = 0; j < NB; j++)
          shadow[k][CW-1-8*j -: 8] <= stage[SBW'(k*NB+j)];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int e = 0; e < NCOEF; e++) mem[e] <= '0;
    end else begin
      if (op_q[0])
        for (int j = 0; j < NB; j++) mem[base_q][CW-1-8*j -: 8] <= stage[SBW'(j)];
      if (op_q[1] && frame_sync)
        for (int k = 0; k < SET; k++) mem[base_q + AW'(k)] <= shadow[k];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int b = 0; b < SB; b++) stage[b] <= '0;
    end else begin
      if (bus_wr && bus_addr < 5'(SB)) stage[SBW'(bus_addr)] <= bus_wdata;
      if (op_q[2])
        for (int j = 0; j < NB; j++) stage[SBW'(j)] <= mem[base_q][CW-1-8*j -: 8];
      if (op_q[3])
        for (int k = 0; k < SET; k++)
          for (int j = 0; j < NB; j++)
            stage[SBW'(k*NB+j)] <= mem[base_q + AW'(k)][CW-1-8*j -: 8];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < 5'(SB)) bus_rdata = stage[SBW'(bus_addr)];
    else if (bus_addr == A_IDX) bus_rdata = 8'(idx_q);
    else if (bus_addr == A_CMD) bus_rdata = {rsv_q, op_q};
    else if (bus_addr == A_STAT) bus_rdata = {6'd0, err_q, busy};
  end

  assign flt_coef = (int'(flt_idx) < NCOEF) ? mem[flt_idx] : '0;

  // R8
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(op_q));
  // R7
  quick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q[0] || op_q[2] || op_q[3]) |=> op_q == 4'd0);
  // R4
  hold_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q[1] && !frame_sync) |=> op_q[1]);
  // R9
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy && req != 4'd0) |=> err_q);
  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, base_q} + ((op_q[1] | op_q[3]) ? (AW+1)'(SET-1) : '0)) <= (AW+1)'(NCOEF-1));
endmodule

// File: tb/coef_loader_tb.sv
module coef_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0, frame_sync = 0;
  logic [4:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [5:0]  flt_idx = 0;
  logic [23:0] flt_coef;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_mem[62];
  int m_stage[15];
  int m_shadow[5];
  int m_idx, m_base, m_op, m_rsv, m_err;

  coef_loader u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_sync(frame_sync),
    .flt_idx(flt_idx), .flt_coef(flt_coef));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int coef3(int b);
    return (m_stage[b] << 16) | (m_stage[b+1] << 8) | m_stage[b+2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      foreach (m_stage[i]) m_stage[i] = 0;
      foreach (m_shadow[i]) m_shadow[i] = 0;
      m_idx = 0; m_base = 0; m_op = 0; m_rsv = 0; m_err = 0;
    end else begin
      int op, base, newop;
      op = m_op; base = m_base; newop = -1;
      if (bus_wr) begin
        int a, d;
        a = int'(bus_addr); d = int'(bus_wdata);
        if (a < 15) m_stage[a] = d;
        else if (a == 16) m_idx = d % 64;
        else if (a == 18) m_err = 0;
        else if (a == 17) begin
          int rq, top;
          m_rsv = d / 16; rq = d % 16;
          if (rq != 0) begin
            top = m_idx + ((rq == 2 || rq == 8) ? 4 : 0);
            if (op != 0 || !(rq == 1 || rq == 2 || rq == 4 || rq == 8) || top > 61) m_err = 1;
            else begin
              newop = rq; m_base = m_idx;
              if (rq == 2) for (int k = 0; k < 5; k++) m_shadow[k] = coef3(3*k);
            end
          end
        end
      end
      if (op == 1) begin m_mem[base] = coef3(0); m_op = 0; end
      if (op == 4) begin
        for (int j = 0; j < 3; j++) m_stage[j] = (m_mem[base] >> (16 - 8*j)) & 255;
        m_op = 0;
      end
      if (op == 8) begin
        for (int k = 0; k < 5; k++)
          for (int j = 0; j < 3; j++) m_stage[3*k+j] = (m_mem[base+k] >> (16 - 8*j)) & 255;
        m_op = 0;
      end
      if (op == 2 && frame_sync) begin
        for (int k = 0; k < 5; k++) m_mem[base+k] = m_shadow[k];
        m_op = 0;
      end
      if (newop > 0) m_op = newop;
    end
  end

  function automatic int model_rd(int a);
    if (a < 15) return m_stage[a];
    if (a == 16) return m_idx;
    if (a == 17) return m_rsv * 16 + m_op;
    if (a == 18) return m_err * 2 + (m_op != 0 ? 1 : 0);
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model rdata", int'(bus_rdata), model_rd(int'(bus_addr)));
    chk("R3 model flt_coef", int'(flt_coef), flt_idx < 62 ? m_mem[flt_idx] : 0);
  end

  task automatic bwr(input int a, input int d);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobe();
    frame_sync = 1; @(posedge clk); #1; frame_sync = 0;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    bus_addr = 5'(a); #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic flt(input int i, input int exp, input string tag);
    flt_idx = 6'(i); #1;
    chk(tag, int'(flt_coef), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    // R1 reset state
    peek(18, 0, "R1 status");
    peek(0, 0, "R1 stage0");
    peek(16, 0, "R1 index");
    peek(17, 0, "R1 command");
    flt(0, 0, "R1 mem0");
    flt(61, 0, "R1 mem61");
    // R2 staging and index
    for (int i = 0; i < 15; i++) bwr(i, 16 + i);
    peek(14, 8'h1E, "R2 stage14");
    bwr(16, 8'hF2);
    peek(16, 8'h32, "R2 index upper bits");
    peek(21, 0, "R2 unmapped");
    // R3 single write
    bwr(16, 50);
    bwr(17, 8'h01);
    peek(18, 1, "R8 busy during single write");
    flt(50, 0, "R3 not yet written");
    idle(1);
    flt(50, 24'h101112, "R3 single write");
    peek(17, 0, "R7 bit0 self clear");
    // R4 atomic commit with reserved bits
    bwr(16, 10);
    bwr(17, 8'hA2);
    bwr(0, 8'hFF);
    idle(3);
    peek(17, 8'hA2, "R4 pending");
    flt(10, 0, "R4 entry 10 held");
    flt(14, 0, "R4 entry 14 held");
    bwr(17, 8'h50);
    peek(17, 8'h52, "R11 zero write keeps op");
    peek(18, 1, "R11 no error");
    bwr(17, 8'hA2);
    strobe();
    flt(10, 24'h101112, "R4 commit b1 uses captured byte");
    flt(11, 24'h131415, "R4 commit b2");
    flt(14, 24'h1C1D1E, "R4 commit b0");
    peek(17, 8'hA0, "R7 reserved kept");
    strobe();
    flt(10, 24'h101112, "R4 idle strobe no effect");
    // R9 busy rejection
    bwr(16, 20);
    bwr(17, 8'h02);
    bwr(17, 8'hA4);
    peek(18, 3, "R9 error while busy");
    peek(17, 8'hA2, "R9 op unchanged");
    strobe();
    flt(20, 24'hFF1112, "R4 second commit");
    bwr(18, 0);
    peek(18, 0, "R10 status write clears error");
    // R10 range and multi-bit
    bwr(16, 58);
    bwr(17, 8'h02);
    peek(18, 2, "R10 five at 58 rejected");
    bwr(18, 0);
    bwr(16, 62);
    bwr(17, 8'h01);
    peek(18, 2, "R10 single at 62 rejected");
    bwr(18, 0);
    bwr(16, 0);
    bwr(17, 8'h03);
    peek(18, 2, "R10 two bits rejected");
    bwr(18, 0);
    bwr(16, 57);
    bwr(17, 8'h08);
    peek(18, 1, "R10 five at 57 accepted");
    idle(1);
    peek(18, 0, "R7 bit3 self clear");
    // R5 single read
    bwr(3, 8'h77);
    bwr(16, 11);
    bwr(17, 8'h04);
    idle(1);
    peek(0, 8'h13, "R5 byte0");
    peek(2, 8'h15, "R5 byte2");
    peek(3, 8'h77, "R5 byte3 untouched");
    // R6 five read
    bwr(16, 10);
    bwr(17, 8'h08);
    idle(1);
    peek(0, 8'h10, "R6 byte0");
    peek(7, 8'h17, "R6 byte7");
    peek(14, 8'h1E, "R6 byte14");
    // R11 zero write idle
    bwr(17, 8'h00);
    peek(18, 0, "R11 idle zero write");
    flt(63, 0, "R2 filter index out of range");
    idle(2);
    finish_run();
  end
endmodule